// File: doc/BRIEF.md
# Strobe-Windowed One-of-Eight Output Decoder

This block turns a 3-bit select code into a one-hot bus of eight lines for a small processor I/O system. A line is driven only inside a time window. The window is set by two timing strobes from the processor: it opens when the first strobe falls and closes when the second strobe falls. The window can open only while the chip-enable input is high.

Both strobes are asynchronous to the system clock. Each one passes through a two-stage synchronizer. A falling edge is recognized when the previous synchronized sample is high and the current one is low. A window flag holds its state between recognized edges. Chip enable gates the outputs combinationally, so several decoders can be stacked for multi-level decoding, and dropping chip enable turns every line off at once. While the window is open, the select code goes straight to the outputs with no latching.

Top module: `strobe_win_decoder`

## Requirements
- R1: A synchronous active-high reset clears the window flag, the synchronizer stages and the edge history. While reset is held and after it is released, all eight outputs stay low until a new opening edge is recognized.
- R2: When chip enable is high and the window flag is set, exactly one output is high. Output bit i is high when the select value equals i (bit 0 for select 3'b000, bit 7 for select 3'b111).
- R3: While chip enable is low, all outputs are low in the same cycle, whatever the strobes and the flag are doing.
- R4: Suppose the opening strobe is high long enough to be sampled and is then driven low, with chip enable high. The flag then sets on the third rising clock edge after the strobe goes low, and the selected output rises after that edge.
- R5: When the closing strobe falls, the flag clears on the third rising clock edge after that fall, and all outputs go low.
- R6: Between recognized edges, with chip enable high, the flag keeps its value. A strobe that stays low or stays high changes nothing.
- R7: If falling edges of both strobes are recognized in the same clock cycle, the closing edge wins and the flag clears.
- R8: While the flag is set, a change on the select input moves the active output within the same cycle, with no clock edge needed.
- R9: A clock edge with chip enable low clears the flag. Raising chip enable again does not reopen the window until a new opening edge is recognized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, active high |
| stb_open | input | 1 | Strobe whose falling edge opens the window (asynchronous) |
| stb_close | input | 1 | Strobe whose falling edge closes the window (asynchronous) |
| sel | input | SEL_W | Select code |
| dec_out | output | 2**SEL_W | One-hot decoded lines |

## Verification
Directed sequences cover six cases:
- the open latency,
- holding the window across strobe levels that do not change,
- closing the window,
- opening and closing edges that land in the same cycle,
- chip enable dropping in the middle of a window,
- select changes between clock edges.

Each directed sequence separates one timing rule from the others. For example, the same-cycle edge case separates "close wins" from "open wins", and the select sweep catches a wrong bit index or a latched select value.

A long constrained-random phase then toggles the strobes with random hold times, switches chip enable only now and then, and changes the select code every cycle. The outputs are compared against a cycle-accurate reference model written from the requirements. This phase finds latency shifts of one cycle and errors in flag priority that the directed cases may not reach.

// File: rtl/strobe_dec_pkg.sv
package strobe_dec_pkg;

  // Action taken on the window flag at a clock edge
  typedef enum logic [1:0] {
    WIN_HOLD  = 2'd0,
    WIN_OPEN  = 2'd1,
    WIN_CLOSE = 2'd2
  } win_act_e;

  // Strobe slot indices used by the top-level generate loop
  localparam int unsigned STB_OPEN_IDX  = 0;
  localparam int unsigned STB_CLOSE_IDX = 1;
  localparam int unsigned STB_COUNT     = 2;

endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              synced;
  logic              hist_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= strobe_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], strobe_in};
      end
    end
  endgenerate

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= synced;
  end

  assign fall_o = hist_q & ~synced;

  // R1
  reset_hist_clear_chk: assert property (@(posedge clk) rst |=> !hist_q && !fall_o)
    else $error("edge history not cleared by reset");

  // R4
  fall_pulse_chk: assert property (@(posedge clk) disable iff (rst) fall_o |=> !fall_o)
    else $error("falling-edge pulse longer than one cycle");

endmodule

// File: rtl/window_flag.sv
module window_flag
  import strobe_dec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic open_fall,
  input  logic close_fall,
  output logic flag_o
);

  win_act_e act;

  always_comb begin
    if (close_fall || !ce) act = WIN_CLOSE;
    else if (open_fall)    act = WIN_OPEN;
    else                   act = WIN_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
    end else begin
      case (act)
        WIN_OPEN:  flag_o <= 1'b1;
        WIN_CLOSE: flag_o <= 1'b0;
        default:   flag_o <= flag_o;
      endcase
    end
  end

  // R1
  flag_reset_chk: assert property (@(posedge clk) rst |=> !flag_o)
    else $error("flag set after reset");

  // R5
  close_clears_chk: assert property (@(posedge clk) disable iff (rst) close_fall |=> !flag_o)
    else $error("closing edge did not clear flag");

  // R7
  both_edges_close_chk: assert property (@(posedge clk) disable iff (rst)
      (open_fall && close_fall) |=> !flag_o)
    else $error("opening edge beat closing edge");

  // R4
  open_sets_chk: assert property (@(posedge clk) disable iff (rst)
      (open_fall && !close_fall && ce) |=> flag_o)
    else $error("opening edge did not set flag");

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!open_fall && !close_fall && ce) |=> $stable(flag_o))
    else $error("flag changed without an edge");

  // R9
  ce_low_clear_chk: assert property (@(posedge clk) disable iff (rst) !ce |=> !flag_o)
    else $error("flag survived chip enable low");

endmodule

// File: rtl/onehot_decode.sv
module onehot_decode #(
  parameter int unsigned SEL_W = 3
) (
  input  logic                     en,
  input  logic [SEL_W-1:0]         sel,
  output logic [(1<<SEL_W)-1:0]    dec_o
);

  localparam int unsigned LINES = 1 << SEL_W;

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_line
      assign dec_o[gi] = en & (sel == SEL_W'(gi));
    end
  endgenerate

endmodule

// File: rtl/strobe_win_decoder.sv
module strobe_win_decoder
  import strobe_dec_pkg::*;
#(
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic                  stb_open,
  input  logic                  stb_close,
  input  logic [SEL_W-1:0]      sel,
  output logic [(1<<SEL_W)-1:0] dec_out
);

  localparam int unsigned LINES = 1 << SEL_W;

  logic [STB_COUNT-1:0] stb_raw;
  logic [STB_COUNT-1:0] stb_fall;
  logic                 win_flag;
  logic                 line_en;

  assign stb_raw[STB_OPEN_IDX]  = stb_open;
  assign stb_raw[STB_CLOSE_IDX] = stb_close;

  genvar gs;
  generate
    for (gs = 0; gs < STB_COUNT; gs++) begin : g_stb
      strobe_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (stb_raw[gs]),
        .fall_o    (stb_fall[gs])
      );
    end
  endgenerate

  window_flag u_flag (
    .clk        (clk),
    .rst        (rst),
    .ce         (ce),
    .open_fall  (stb_fall[STB_OPEN_IDX]),
    .close_fall (stb_fall[STB_CLOSE_IDX]),
    .flag_o     (win_flag)
  );

  assign line_en = ce & win_flag;

  onehot_decode #(.SEL_W(SEL_W)) u_dec (
    .en    (line_en),
    .sel   (sel),
    .dec_o (dec_out)
  );

  // R2
  onehot_out_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(dec_out))
    else $error("more than one line active");

  // R2
  selected_line_chk: assert property (@(posedge clk) disable iff (rst)
      (ce && win_flag) |-> (dec_out[sel] && $countones(dec_out) == 1))
    else $error("active line does not match select");

  // R3
  ce_gate_chk: assert property (@(posedge clk) disable iff (rst) !ce |-> (dec_out == '0))
    else $error("line active with chip enable low");

  // R5
  closed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !win_flag |-> (dec_out == '0))
    else $error("line active while window closed");

  initial begin
    if (LINES < 2) $error("decoder needs at least two lines");
  end

endmodule

// File: tb/strobe_win_decoder_tb.sv
module strobe_win_decoder_tb;

  localparam int SEL_W = 3;
  localparam int LINES = 1 << SEL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ce = 1'b0;
  logic             stb_open = 1'b1;
  logic             stb_close = 1'b1;
  logic [SEL_W-1:0] sel = '0;
  logic [LINES-1:0] dec_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  strobe_win_decoder #(.SEL_W(SEL_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .stb_open(stb_open),
    .stb_close(stb_close), .sel(sel), .dec_out(dec_out)
  );

  // Reference model: two sync stages, one history register, one flag per requirements
  logic ma1 = 0, ma2 = 0, mah = 0, mb1 = 0, mb2 = 0, mbh = 0, mflag = 0;
  always @(posedge clk) begin
    if (rst) begin
      ma1 <= 0; ma2 <= 0; mah <= 0; mb1 <= 0; mb2 <= 0; mbh <= 0; mflag <= 0;
    end else begin
      ma1 <= stb_open;  ma2 <= ma1; mah <= ma2;
      mb1 <= stb_close; mb2 <= mb1; mbh <= mb2;
      if ((mbh && !mb2) || !ce)  mflag <= 1'b0;
      else if (mah && !ma2)      mflag <= 1'b1;
    end
  end

  function automatic logic [LINES-1:0] exp_lines(input logic e, input logic f,
                                                 input logic [SEL_W-1:0] s);
    logic [LINES-1:0] v;
    v = '0;
    if (e && f) v[s] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [LINES-1:0] exp);
    n_checks++;
    if (dec_out !== exp) begin
      n_fail++;
      $display("FAIL %s: dec_out=%b expected=%b (ce=%b sel=%0d)", tag, dec_out, exp, ce, sel);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int k = 0;
    while (!done && k < 100000) begin @(posedge clk); k++; end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1853));
    cyc(3);
    // R1: outputs low in reset
    check("R1 during reset", '0);
    rst = 1'b0; ce = 1'b1; sel = 3'd5;
    cyc(3);
    check("R1 after reset, no edge", '0);

    // R4: opening edge latency
    stb_open = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R4 not open after two edges", '0);
    @(posedge clk); #1;
    check("R4 open after third edge", 8'b0010_0000);

    // R6: strobe return high, hold
    @(negedge clk); stb_open = 1'b1;
    cyc(6);
    check("R6 flag holds", 8'b0010_0000);

    // R8 and R2: select sweep, no clock edge needed
    for (int s = 0; s < LINES; s++) begin
      @(negedge clk); sel = SEL_W'(s); #0.5;
      check("R8 same-cycle move", exp_lines(1'b1, 1'b1, SEL_W'(s)));
      check("R2 index mapping", LINES'(1) << s);
    end

    // R5: closing edge
    @(negedge clk); stb_close = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R5 still open after two edges", exp_lines(1'b1, 1'b1, sel));
    @(posedge clk); #1;
    check("R5 closed after third edge", '0);
    @(negedge clk); stb_close = 1'b1; cyc(4);
    check("R6 closed holds", '0);

    // R7: simultaneous edges
    @(negedge clk); stb_open = 1'b0; stb_close = 1'b0;
    cyc(4);
    check("R7 close wins", '0);
    @(negedge clk); stb_open = 1'b1; stb_close = 1'b1; cyc(4);

    // reopen, then R3 and R9
    @(negedge clk); stb_open = 1'b0; sel = 3'd2; cyc(4);
    check("R4 reopened", 8'b0000_0100);
    @(negedge clk); stb_open = 1'b1; ce = 1'b0; #0.5;
    check("R3 ce low immediate", '0);
    cyc(2);
    ce = 1'b1; #0.5;
    check("R9 flag cleared by ce low", '0);
    cyc(3);
    check("R9 stays closed", '0);

    // Random phase against reference model
    begin
      int hold_a = 0, hold_b = 0;
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        if (hold_a == 0) begin stb_open  = ~stb_open;  hold_a = 1 + ($urandom % 8); end
        else hold_a--;
        if (hold_b == 0) begin stb_close = ~stb_close; hold_b = 1 + ($urandom % 12); end
        else hold_b--;
        if (($urandom % 40) == 0) ce = ~ce;
        sel = SEL_W'($urandom);
        #0.5;
        if (!ce)        check("R3 random", exp_lines(ce, mflag, sel));
        else if (mflag) check("R2 random", exp_lines(ce, mflag, sel));
        else            check("R6 random", exp_lines(ce, mflag, sel));
      end
    end

    // R1: reset mid-window
    @(negedge clk); ce = 1'b1; stb_open = 1'b1; stb_close = 1'b1; cyc(3);
    @(negedge clk); stb_open = 1'b0; cyc(4);
    @(negedge clk); rst = 1'b1; cyc(2);
    check("R1 reset closes window", '0);
    rst = 1'b0; cyc(4);
    check("R1 no reopen after reset", '0);

    done = 1'b1;
    summary();
  end

endmodule